// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a small synchronous static RAM built for a shared data bus that never idles. Reads and writes can be issued on consecutive clocks in any mix. Address, control and byte enables are sampled on the rising edge of the clock. Write data arrives later than its address, so a read can be followed directly by a write with no dead cycle on the bus. A static mode pin selects between two timings. In pipelined timing, read data passes through an output register and write data follows its address by two clocks. In flow-through timing, read data comes straight from the array and write data follows its address by one clock.

Bursts of four beats are supported. An advance input steps the low two address bits of the last loaded command, in either linear or interleaved order. Three chip enables allow depth expansion. Per-byte write enables on 9-bit bytes allow partial writes. A read that hits a write still waiting for its data returns the merged new data, so results stay coherent. The output enable and the sleep pin act on the output drive asynchronously. Sleep also blocks new commands.

Top module: `nbt_sram_core`

## Requirements
- R1: A command is accepted only when ce1_ni=0, ce2_i=1 and ce3_ni=0 at the rising edge. Any other combination (with adv_i=0) is a deselect that neither reads nor writes.
- R2: With pipe_mode_i=1, data for a read sampled at edge k is driven on rdata_o, with rdata_oe_o=1, after edge k+1 and until edge k+2.
- R3: With pipe_mode_i=0, data for a read sampled at edge k is driven right after edge k and until edge k+1.
- R4: Data for a write sampled at edge k is taken from wdata_i at edge k+2 when pipe_mode_i=1, and at edge k+1 when pipe_mode_i=0.
- R5: Reads and writes may alternate on consecutive edges with no idle cycle, and every access completes correctly.
- R6: In pipelined timing, a read whose address matches a write still waiting for its data returns that data, merged byte by byte with the stored word.
- R7: bwe_ni[b]=0 on a write enables byte b, which is bits 9b+8 down to 9b. Bytes with bwe_ni[b]=1 keep their old contents.
- R8: adv_i=1 repeats the previous command type at the next burst address. The upper address bits are held. With beat index n, the low two bits are (start+n) mod 4 when linear_i=1, and start XOR n when linear_i=0. An advance after a deselect is a deselect.
- R9: oe_ni=1 turns rdata_oe_o off at once, without a clock, and forces rdata_o to zero. rdata_o is zero whenever rdata_oe_o=0.
- R10: sleep_i=1 turns the output drive off at once. Commands sampled while it is high are ignored. Writes already issued still complete.
- R11: After reset, no access is in flight and rdata_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | Static timing select: 1 pipelined, 0 flow-through |
| linear_i | input | 1 | Static burst order select: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Asynchronous power-down request |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write command, active low (1 = read) |
| adv_i | input | 1 | Burst advance instead of a new load |
| bwe_ni | input | 2 | Per-byte write enables, active low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 18 | Late write data |
| rdata_o | output | 18 | Read data, zero when not driving |
| rdata_oe_o | output | 1 | Read data drive enable |

## Verification
The assertions assume that pipe_mode_i and linear_i stay fixed while accesses are in flight. They also assume that wdata_i carries the data of a pending write on the edge where that write expects it. The stimulus changes both mode pins only inside a reset. It drives wdata_i on each step according to the mode's write latency, and drives zero on edges that no write claims. All inputs change only at the falling clock edge. The exception is oe_ni, which is toggled within a cycle to test its immediate effect.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int unsigned BEAT_W = 2;

  // next low address bits of a 4-beat burst
  function automatic logic [BEAT_W-1:0] burst_low(input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] beat,
                                                   input logic linear);
    return linear ? start + beat : start ^ beat;
  endfunction
endpackage

// File: rtl/nbt_burst_ctl.sv
module nbt_burst_ctl #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              linear_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              we_ni,
  input  logic              adv_i,
  input  logic [NB-1:0]     bwe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_vld_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [NB-1:0]     cmd_be_o
);
  import nbt_pkg::*;
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              vld_q, wr_q;
  logic [HI_W-1:0]   base_q;
  logic [BEAT_W-1:0] start_q, beat_q;
  logic [NB-1:0]     be_q;
  logic              sel;

  assign sel = !ce1_ni && ce2_i && !ce3_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      be_q    <= '0;
    end else if (sleep_i) begin
      vld_q <= 1'b0;
    end else if (adv_i) begin
      beat_q <= beat_q + 1'b1;
    end else begin
      vld_q   <= sel;
      wr_q    <= !we_ni;
      base_q  <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
      beat_q  <= '0;
      be_q    <= ~bwe_ni;
    end
  end

  assign cmd_vld_o  = vld_q;
  assign cmd_wr_o   = wr_q;
  assign cmd_be_o   = be_q;
  assign cmd_addr_o = {base_q, burst_low(start_q, beat_q, linear_i)};

  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adv_i && (ce1_ni || !ce2_i || ce3_ni)) |=> !cmd_vld_o); // R1
  AST_SLEEP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !cmd_vld_o); // R10
  AST_ADV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !sleep_i) |=> ($stable(cmd_addr_o[ADDR_W-1:BEAT_W]) && $stable(cmd_wr_o))); // R8
  AST_ADV_LINEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !sleep_i && linear_i) |=>
      (!linear_i || cmd_addr_o[BEAT_W-1:0] == $past(cmd_addr_o[BEAT_W-1:0]) + 2'd1)); // R8
endmodule

// File: rtl/nbt_late_write.sv
module nbt_late_write #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              cmd_vld_i,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [NB-1:0]     cmd_be_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [NB-1:0]     wr_be_o
);
  logic              s2_vld_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [NB-1:0]     s2_be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q  <= 1'b0;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
    end else begin
      s2_vld_q  <= cmd_vld_i && cmd_wr_i;
      s2_addr_q <= cmd_addr_i;
      s2_be_q   <= cmd_be_i;
    end
  end

  // double late write in pipelined timing, single late write otherwise
  assign wr_en_o   = pipe_i ? s2_vld_q  : (cmd_vld_i && cmd_wr_i);
  assign wr_addr_o = pipe_i ? s2_addr_q : cmd_addr_i;
  assign wr_be_o   = pipe_i ? s2_be_q   : cmd_be_i;

  AST_PIPE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && cmd_vld_i && cmd_wr_i) |=> (!pipe_i || (wr_en_o && wr_addr_o == $past(cmd_addr_i)))); // R4
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2,
  parameter int unsigned BYTE_W = 9
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [NB-1:0]        wbe_i,
  input  logic [NB*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [NB*BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[b]) mem_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/nbt_sram_core.sv
module nbt_sram_core #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DATA_W = NB * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              linear_i,
  input  logic              sleep_i,
  input  logic              oe_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              we_ni,
  input  logic              adv_i,
  input  logic [NB-1:0]     bwe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              c_vld, c_wr;
  logic [ADDR_W-1:0] c_addr;
  logic [NB-1:0]     c_be;
  logic              w_en;
  logic [ADDR_W-1:0] w_addr;
  logic [NB-1:0]     w_be;
  logic [DATA_W-1:0] ram_q, merged, out_q, data_sync;
  logic              out_vld_q, rd_now, byp_hit, drive_sync;

  nbt_burst_ctl #(.ADDR_W(ADDR_W), .NB(NB)) u_burst (
    .clk_i, .rst_ni, .sleep_i, .linear_i, .ce1_ni, .ce2_i, .ce3_ni, .we_ni,
    .adv_i, .bwe_ni, .addr_i,
    .cmd_vld_o(c_vld), .cmd_wr_o(c_wr), .cmd_addr_o(c_addr), .cmd_be_o(c_be)
  );

  nbt_late_write #(.ADDR_W(ADDR_W), .NB(NB)) u_lw (
    .clk_i, .rst_ni, .pipe_i(pipe_mode_i),
    .cmd_vld_i(c_vld), .cmd_wr_i(c_wr), .cmd_addr_i(c_addr), .cmd_be_i(c_be),
    .wr_en_o(w_en), .wr_addr_o(w_addr), .wr_be_o(w_be)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) u_ram (
    .clk_i, .we_i(w_en), .waddr_i(w_addr), .wbe_i(w_be), .wdata_i,
    .raddr_i(c_addr), .rdata_o(ram_q)
  );

  assign rd_now  = c_vld && !c_wr;
  assign byp_hit = w_en && (w_addr == c_addr);

  // forward bytes of a write committing on this edge
  for (genvar b = 0; b < NB; b++) begin : g_byp
    assign merged[b*BYTE_W +: BYTE_W] = (byp_hit && w_be[b]) ?
      wdata_i[b*BYTE_W +: BYTE_W] : ram_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else begin
      out_vld_q <= rd_now;
      if (rd_now) out_q <= merged;
    end
  end

  assign drive_sync = pipe_mode_i ? out_vld_q : rd_now;
  assign data_sync  = pipe_mode_i ? out_q : merged;
  assign rdata_oe_o = drive_sync && !oe_ni && !sleep_i;
  assign rdata_o    = rdata_oe_o ? data_sync : '0;

  AST_PIPE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && rd_now) |=> (!pipe_mode_i || oe_ni || sleep_i || rdata_oe_o)); // R2
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && rd_now && byp_hit && (&w_be)) |=> (out_q == $past(wdata_i))); // R6
endmodule

// File: tb/tb_nbt_sram_core.sv
module tb_nbt_sram_core;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 18;
  localparam int unsigned NV = 11;

  typedef struct packed {
    logic [1:0]    kind;   // 0 deselect, 1 read, 2 write, 3 advance
    logic [AW-1:0] addr;
    logic [1:0]    bwe_n;
    logic [DW-1:0] wd;
    logic          exp_drv;
    logic [DW-1:0] exp_q;
  } vec_t;

  // pipelined timing, sampled just after each edge
  localparam vec_t VECS [NV] = '{
    '{2'd2, 6'd4, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{2'd2, 6'd5, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{2'd1, 6'd4, 2'b00, 18'h12345, 1'b0, 18'h00000},
    '{2'd2, 6'd6, 2'b00, 18'h0ABCD, 1'b1, 18'h12345},
    '{2'd1, 6'd6, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{2'd1, 6'd5, 2'b00, 18'h3C3C3, 1'b1, 18'h3C3C3},
    '{2'd2, 6'd4, 2'b10, 18'h00000, 1'b1, 18'h0ABCD},
    '{2'd0, 6'd0, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{2'd0, 6'd0, 2'b00, 18'h3FFFF, 1'b0, 18'h00000},
    '{2'd1, 6'd4, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{2'd0, 6'd0, 2'b00, 18'h00000, 1'b1, 18'h123FF}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pipe_mode_i = 1'b0, linear_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic ce1_ni = 1'b1, ce2_i = 1'b1, ce3_ni = 1'b0, we_ni = 1'b1, adv_i = 1'b0;
  logic [1:0] bwe_ni = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rdata_oe_o;
  int checks = 0, failures = 0;

  always #4 clk_i = ~clk_i;

  nbt_sram_core dut (
    .clk_i, .rst_ni, .pipe_mode_i, .linear_i, .sleep_i, .oe_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .we_ni, .adv_i, .bwe_ni, .addr_i,
    .wdata_i, .rdata_o, .rdata_oe_o
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] kind, input logic [AW-1:0] a,
                       input logic [1:0] bn, input logic [DW-1:0] wd);
    ce1_ni  = (kind == 2'd0);
    ce2_i   = 1'b1;
    ce3_ni  = 1'b0;
    we_ni   = (kind != 2'd2);
    adv_i   = (kind == 2'd3);
    addr_i  = a;
    bwe_ni  = bn;
    wdata_i = wd;
  endtask

  task automatic step(input logic [1:0] kind, input logic [AW-1:0] a,
                      input logic [1:0] bn, input logic [DW-1:0] wd);
    @(negedge clk_i);
    drive(kind, a, bn, wd);
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(input logic pm, input logic lin);
    @(negedge clk_i);
    rst_ni = 1'b0;
    pipe_mode_i = pm;
    linear_i = lin;
    drive(2'd0, '0, 2'b11, '0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R11 reset drive", {17'd0, rdata_oe_o}, 18'd0);
    chk("R11 reset data", rdata_o, 18'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // flow-through timing, interleaved bursts
    do_reset(1'b0, 1'b0);
    step(2'd2, 6'd8, 2'b00, 18'h0);
    chk("R3 no drive on write", {17'd0, rdata_oe_o}, 18'd0);
    step(2'd1, 6'd8, 2'b00, 18'h15555);
    chk("R4 R5 flow write then read", rdata_o, 18'h15555);
    step(2'd2, 6'd16, 2'b00, 18'h0);
    step(2'd2, 6'd17, 2'b00, 18'h00110);
    step(2'd2, 6'd18, 2'b00, 18'h00111);
    step(2'd2, 6'd19, 2'b00, 18'h00112);
    step(2'd0, 6'd0,  2'b00, 18'h00113);
    step(2'd1, 6'd17, 2'b00, 18'h0);
    chk("R3 flow read same cycle", rdata_o, 18'h00111);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R8 interleave beat1", rdata_o, 18'h00110);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R8 interleave beat2", rdata_o, 18'h00113);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R8 interleave beat3", rdata_o, 18'h00112);
    // deselected write and read
    @(negedge clk_i);
    drive(2'd2, 6'd16, 2'b00, 18'h0);
    ce2_i = 1'b0;
    @(posedge clk_i); #1;
    step(2'd0, 6'd0, 2'b00, 18'h3FFFF);
    step(2'd1, 6'd16, 2'b00, 18'h0);
    chk("R1 deselected write ignored", rdata_o, 18'h00110);
    @(negedge clk_i);
    drive(2'd1, 6'd16, 2'b00, 18'h0);
    ce3_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 deselected read no drive", {17'd0, rdata_oe_o}, 18'd0);

    // pipelined timing, linear bursts
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].kind, VECS[i].addr, VECS[i].bwe_n, VECS[i].wd);
      chk("R2 R4 R5 R7 vector drive", {17'd0, rdata_oe_o}, {17'd0, VECS[i].exp_drv});
      if (VECS[i].exp_drv) chk("R2 R6 R7 vector data", rdata_o, VECS[i].exp_q);
    end
    step(2'd1, 6'd18, 2'b00, 18'h0);
    chk("R2 pipe read not yet", {17'd0, rdata_oe_o}, 18'd0);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R2 R8 linear beat0", rdata_o, 18'h00112);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R8 linear beat1", rdata_o, 18'h00113);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    chk("R8 linear wrap beat2", rdata_o, 18'h00110);
    step(2'd0, 6'd0, 2'b00, 18'h0);
    chk("R8 linear beat3", rdata_o, 18'h00111);
    step(2'd3, 6'd0, 2'b00, 18'h0);
    step(2'd0, 6'd0, 2'b00, 18'h0);
    chk("R8 advance after deselect", {17'd0, rdata_oe_o}, 18'd0);
    // async output enable
    step(2'd1, 6'd16, 2'b00, 18'h0);
    step(2'd0, 6'd0, 2'b00, 18'h0);
    chk("R9 drive before oe", rdata_o, 18'h00110);
    oe_ni = 1'b1; #1;
    chk("R9 oe off drive", {17'd0, rdata_oe_o}, 18'd0);
    chk("R9 oe off data", rdata_o, 18'd0);
    oe_ni = 1'b0; #1;
    chk("R9 oe back on", rdata_o, 18'h00110);
    // sleep
    step(2'd1, 6'd17, 2'b00, 18'h0);
    @(negedge clk_i);
    drive(2'd2, 6'd16, 2'b00, 18'h0);
    sleep_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R10 sleep stops drive", {17'd0, rdata_oe_o}, 18'd0);
    step(2'd0, 6'd0, 2'b00, 18'h0);
    step(2'd0, 6'd0, 2'b00, 18'h3FFFF);
    sleep_i = 1'b0;
    step(2'd1, 6'd16, 2'b00, 18'h0);
    step(2'd0, 6'd0, 2'b00, 18'h0);
    chk("R10 write during sleep ignored", rdata_o, 18'h00110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule